// File: doc/BRIEF.md
# Page access guard with fault status logging

This block sits after a page-table walker. For each translation it is given the leaf entry's 3-bit access field, the entry's modified bit, the kind of access (read, write, instruction fetch) and whether the requester runs in user mode. It decides whether the access is allowed. If it is, the block hands back the read, write and execute rights for the page. If it is not, the block either requests a trap or, when the no-fault control bit is set or traps are off, grants full rights so that execution can continue. A nonzero fault code from the walker counts as a fault and takes the place of the block's own check.

Every fault, trapped or not, is logged in a fault status register together with the faulting virtual address. If software has not read an earlier fault before the next one arrives, the log marks the overflow. Reading the status register clears it at the next clock edge.

Top module: `acc_guard`

## Requirements
- R1: The access index is {req_write, req_fetch, !req_user}, bit 2 first. The check code is 0 when the access is allowed, 8 on a protection error and 12 on a privilege error. An access is allowed when the rights of the field, as seen from the requester's mode, cover the need: write needs W, fetch needs X, and a plain read needs R.
- R2: Rights per field value, given as read/write/execute, for both modes: 0 R, 1 RW, 2 RX, 3 RWX, 4 X. In supervisor mode 5 gives RW, 6 gives RX and 7 gives RWX. In user mode 5 gives R only. In user mode 6 and 7 give nothing and always fail with code 12.
- R3: An allowed access with no walker fault sets grant_r, grant_w and grant_x to the rights of R2 for the requester's mode. trap_req stays 0.
- R4: On an allowed access, grant_w is 1 only if leaf_mod is 1.
- R5: On a fault while fsr_q is zero, fsr_q becomes (index<<5) | code | 2 at the next clock edge, and far_q takes req_vaddr.
- R6: On a fault while fsr_q is nonzero and sts_rd is low, the new value is 1 | (index<<5) | code | 2. Bit 0 marks the overflow.
- R7: A cycle with sts_rd high and no fault clears fsr_q at the next edge. If a fault arrives in the same cycle as sts_rd, it is logged without the overflow bit.
- R8: A nonzero walk_code is itself the fault code. It replaces the access check, so it faults even when the access field would allow the access.
- R9: When nf_mode is 1 or trap_en is 0, a fault does not raise trap_req and all three grants are 1. The fault is still logged.
- R10: A trapped fault sets trap_req, with trap_inst equal to req_fetch (1 means instruction-access fault, 0 means data-access fault). During a trap all grants are 0.
- R11: With req_valid low, the grants and trap_req are 0, and fsr_q and far_q keep their values unless sts_rd clears fsr_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A translation is presented this cycle |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Requester is in user mode |
| leaf_acc | input | 3 | Access field of the leaf entry |
| leaf_mod | input | 1 | Modified bit of the leaf entry |
| walk_code | input | FS_W | Walker fault code, zero when the walk succeeded |
| nf_mode | input | 1 | No-fault control bit |
| trap_en | input | 1 | Traps enabled |
| sts_rd | input | 1 | Software read strobe of the status register |
| grant_r | output | 1 | Read right granted |
| grant_w | output | 1 | Write right granted |
| grant_x | output | 1 | Execute right granted |
| trap_req | output | 1 | Take a fault trap |
| trap_inst | output | 1 | Trap is an instruction-access fault |
| fsr_q | output | FS_W | Fault status register |
| far_q | output | VA_W | Fault address register |

## Verification
The hardest state to reach is a second fault that arrives while the status register still holds an earlier one, and especially the case where that fault lands in the very cycle software reads the register. The stimulus gets there by issuing faulting requests back to back with no read strobe in between. It then raises sts_rd in the same cycle as a further fault and checks that the overflow bit is dropped. The main sweep instead clears the register before each request, so that every pairing of access index, access field and modified bit is checked against a clean log.

// File: rtl/acg_pkg.sv
package acg_pkg;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
   } rights_t;

   localparam logic [3:0] CODE_OK   = 4'd0;
   localparam logic [3:0] CODE_PROT = 4'd8;
   localparam logic [3:0] CODE_PRIV = 4'd12;

   localparam int IDX_SHIFT = 5;
   localparam int MIN_FS_W  = IDX_SHIFT + 3;

   // Rights of an access field as seen from one privilege level.
   function automatic rights_t field_rights(input logic [2:0] fld, input logic sup);
      rights_t rt;
      rt = '0;
      if (!fld[2]) begin
         rt.r = 1'b1;
         rt.w = fld[0];
         rt.x = fld[1];
      end else if (fld[1:0] == 2'b00) begin
         rt.x = 1'b1;
      end else if (sup) begin
         rt.r = 1'b1;
         rt.w = fld[0];
         rt.x = fld[1];
      end else if (fld[1:0] == 2'b01) begin
         rt.r = 1'b1;
      end
      return rt;
   endfunction

endpackage

// File: rtl/acg_perm.sv
module acg_perm
   import acg_pkg::*;
(
   input  logic       is_write,
   input  logic       is_fetch,
   input  logic       is_user,
   input  logic [2:0] fld,
   output logic [2:0] acc_idx,
   output logic [3:0] chk_code,
   output rights_t    rights
);

   logic    need_r;
   logic    short;
   logic    priv_bad;

   assign acc_idx  = {is_write, is_fetch, ~is_user};
   assign rights   = field_rights(fld, ~is_user);
   assign need_r   = ~is_write & ~is_fetch;
   assign priv_bad = is_user & fld[2] & fld[1];
   assign short    = (is_write & ~rights.w) | (is_fetch & ~rights.x) | (need_r & ~rights.r);

   always_comb begin
      if (priv_bad)   chk_code = CODE_PRIV;
      else if (short) chk_code = CODE_PROT;
      else            chk_code = CODE_OK;
   end

endmodule

// File: rtl/acg_fsr.sv
module acg_fsr
   import acg_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int FS_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            log_en,
   input  logic [2:0]      log_idx,
   input  logic [FS_W-1:0] log_code,
   input  logic [VA_W-1:0] log_addr,
   input  logic            rd_clr,
   output logic [FS_W-1:0] fsr_q,
   output logic [VA_W-1:0] far_q
);

   localparam int PAD_W = FS_W - MIN_FS_W;

   logic [FS_W-1:0] idx_field;
   logic [FS_W-1:0] ovf_field;
   logic [FS_W-1:0] fsr_nxt;

   assign idx_field = {{PAD_W{1'b0}}, log_idx, {IDX_SHIFT{1'b0}}};
   // Overflow only when an unread entry is being replaced.
   assign ovf_field = (!rd_clr && fsr_q != '0) ? FS_W'(1) : '0;

   always_comb begin
      fsr_nxt = fsr_q;
      if (log_en)      fsr_nxt = ovf_field | idx_field | log_code | FS_W'(2);
      else if (rd_clr) fsr_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsr_q <= '0;
         far_q <= '0;
      end else begin
         fsr_q <= fsr_nxt;
         if (log_en) far_q <= log_addr;
      end
   end

endmodule

// File: rtl/acg_grant.sv
module acg_grant
   import acg_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    valid,
   input  logic    fault,
   input  logic    override,
   input  logic    dirty,
   input  logic    fetch,
   input  rights_t rights,
   output logic    grant_r,
   output logic    grant_w,
   output logic    grant_x,
   output logic    trap_req,
   output logic    trap_inst
);

   rights_t g_nxt;
   logic    t_nxt;
   logic    k_nxt;

   always_comb begin
      g_nxt = '0;
      t_nxt = 1'b0;
      k_nxt = 1'b0;
      if (valid) begin
         if (!fault) begin
            g_nxt   = rights;
            g_nxt.w = rights.w & dirty;
         end else if (override) begin
            g_nxt = '{r: 1'b1, w: 1'b1, x: 1'b1};
         end else begin
            t_nxt = 1'b1;
            k_nxt = fetch;
         end
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               {grant_r, grant_w, grant_x} <= '0;
               trap_req  <= 1'b0;
               trap_inst <= 1'b0;
            end else begin
               {grant_r, grant_w, grant_x} <= g_nxt;
               trap_req  <= t_nxt;
               trap_inst <= k_nxt;
            end
         end
      end else begin : g_comb
         assign {grant_r, grant_w, grant_x} = g_nxt;
         assign trap_req  = t_nxt;
         assign trap_inst = k_nxt;
      end
   endgenerate

endmodule

// File: rtl/acc_guard.sv
module acc_guard
   import acg_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int FS_W    = 12,
   parameter bit REG_OUT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_write,
   input  logic            req_fetch,
   input  logic            req_user,
   input  logic [2:0]      leaf_acc,
   input  logic            leaf_mod,
   input  logic [FS_W-1:0] walk_code,
   input  logic            nf_mode,
   input  logic            trap_en,
   input  logic            sts_rd,
   output logic            grant_r,
   output logic            grant_w,
   output logic            grant_x,
   output logic            trap_req,
   output logic            trap_inst,
   output logic [FS_W-1:0] fsr_q,
   output logic [VA_W-1:0] far_q
);

   generate
      if (FS_W < MIN_FS_W) begin : g_bad_fs
         $error("acc_guard: FS_W too small for the access index field");
      end
      if (VA_W < 1) begin : g_bad_va
         $error("acc_guard: VA_W must be positive");
      end
   endgenerate

   logic [2:0]      acc_idx;
   logic [3:0]      chk_code;
   rights_t         rights;
   logic [FS_W-1:0] flt_code;
   logic            flt_hit;
   logic            no_trap;

   acg_perm u_perm (
      .is_write (req_write),
      .is_fetch (req_fetch),
      .is_user  (req_user),
      .fld      (leaf_acc),
      .acc_idx  (acc_idx),
      .chk_code (chk_code),
      .rights   (rights)
   );

   // A walker fault supersedes the access check.
   assign flt_code = (walk_code != '0) ? walk_code : {{(FS_W-4){1'b0}}, chk_code};
   assign flt_hit  = req_valid && (flt_code != '0);
   assign no_trap  = nf_mode || !trap_en;

   acg_grant #(.REG_OUT(REG_OUT)) u_grant (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (req_valid),
      .fault     (flt_code != '0),
      .override  (no_trap),
      .dirty     (leaf_mod),
      .fetch     (req_fetch),
      .rights    (rights),
      .grant_r   (grant_r),
      .grant_w   (grant_w),
      .grant_x   (grant_x),
      .trap_req  (trap_req),
      .trap_inst (trap_inst)
   );

   acg_fsr #(.VA_W(VA_W), .FS_W(FS_W)) u_fsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .log_en   (flt_hit),
      .log_idx  (acc_idx),
      .log_code (flt_code),
      .log_addr (req_vaddr),
      .rd_clr   (sts_rd),
      .fsr_q    (fsr_q),
      .far_q    (far_q)
   );

endmodule

// File: rtl/acc_guard_chk.sv
module acc_guard_chk #(
   parameter int VA_W    = 32,
   parameter int FS_W    = 12,
   parameter bit REG_OUT = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic            req_fetch,
   input logic            leaf_mod,
   input logic            nf_mode,
   input logic            trap_en,
   input logic            sts_rd,
   input logic            flt_hit,
   input logic            grant_r,
   input logic            grant_w,
   input logic            grant_x,
   input logic            trap_req,
   input logic            trap_inst,
   input logic [FS_W-1:0] fsr_q,
   input logic [VA_W-1:0] far_q
);

   assert_trap_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> !(grant_r || grant_w || grant_x));

   assert_log_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flt_hit |=> (fsr_q[1] && far_q == $past(req_vaddr)));

   assert_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_hit && fsr_q != '0 && !sts_rd) |=> fsr_q[0]);

   assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd && !flt_hit) |=> fsr_q == '0);

   assert_fresh_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd && flt_hit) |=> !fsr_q[0]);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!flt_hit && !sts_rd) |=> ($stable(fsr_q) && $stable(far_q)));

   generate
      if (!REG_OUT) begin : g_same_cycle
         assert_dirty_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && grant_w && !leaf_mod) |-> (nf_mode || !trap_en));

         assert_trap_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
            trap_req |-> (trap_inst == req_fetch));

         assert_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_hit && (nf_mode || !trap_en)) |-> (!trap_req && grant_r && grant_w && grant_x));

         assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |-> !(trap_req || grant_r || grant_w || grant_x));
      end
   endgenerate

endmodule

bind acc_guard acc_guard_chk #(.VA_W(VA_W), .FS_W(FS_W), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_vaddr (req_vaddr),
   .req_fetch (req_fetch),
   .leaf_mod  (leaf_mod),
   .nf_mode   (nf_mode),
   .trap_en   (trap_en),
   .sts_rd    (sts_rd),
   .flt_hit   (flt_hit),
   .grant_r   (grant_r),
   .grant_w   (grant_w),
   .grant_x   (grant_x),
   .trap_req  (trap_req),
   .trap_inst (trap_inst),
   .fsr_q     (fsr_q),
   .far_q     (far_q)
);

// File: tb/test_acc_guard.sv
module test_acc_guard;

   localparam int VA_W = 32;
   localparam int FS_W = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [VA_W-1:0] req_vaddr = '0;
   logic            req_write = 1'b0;
   logic            req_fetch = 1'b0;
   logic            req_user = 1'b0;
   logic [2:0]      leaf_acc = '0;
   logic            leaf_mod = 1'b0;
   logic [FS_W-1:0] walk_code = '0;
   logic            nf_mode = 1'b0;
   logic            trap_en = 1'b1;
   logic            sts_rd = 1'b0;
   logic            grant_r, grant_w, grant_x, trap_req, trap_inst;
   logic [FS_W-1:0] fsr_q;
   logic [VA_W-1:0] far_q;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   acc_guard #(.VA_W(VA_W), .FS_W(FS_W)) i_acc_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
      .leaf_acc(leaf_acc), .leaf_mod(leaf_mod), .walk_code(walk_code),
      .nf_mode(nf_mode), .trap_en(trap_en), .sts_rd(sts_rd),
      .grant_r(grant_r), .grant_w(grant_w), .grant_x(grant_x),
      .trap_req(trap_req), .trap_inst(trap_inst), .fsr_q(fsr_q), .far_q(far_q)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Expected check code, one nibble per field value, one word per access index.
   function automatic logic [3:0] exp_code(input int idx, input int fld);
      logic [31:0] row;
      case (idx)
         0: row = 32'hCC080000;
         1: row = 32'h00080000;
         2: row = 32'hCC800088;
         3: row = 32'h00800088;
         4: row = 32'hCC880808;
         5: row = 32'h08080808;
         6: row = 32'hCC880888;
         default: row = 32'h08880888;
      endcase
      return row[fld*4 +: 4];
   endfunction

   // Expected {r,w,x} per mode and field.
   function automatic logic [2:0] exp_rights(input bit user, input int fld);
      case (fld)
         0: return 3'b100;
         1: return 3'b110;
         2: return 3'b101;
         3: return 3'b111;
         4: return 3'b001;
         5: return user ? 3'b100 : 3'b110;
         6: return user ? 3'b000 : 3'b101;
         default: return user ? 3'b000 : 3'b111;
      endcase
   endfunction

   task automatic drive_req(input int idx, input int fld, input bit mod, input logic [31:0] va);
      req_valid = 1'b1;
      req_write = idx[2];
      req_fetch = idx[1];
      req_user  = ~idx[0];
      leaf_acc  = fld[2:0];
      leaf_mod  = mod;
      req_vaddr = va;
   endtask

   task automatic idle();
      req_valid = 1'b0;
      walk_code = '0;
      sts_rd    = 1'b0;
   endtask

   task automatic clear_fsr();
      idle();
      sts_rd = 1'b1;
      @(negedge clk);
      sts_rd = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [3:0]  code;
      logic [2:0]  rt;
      logic [31:0] va;
      repeat (3) @(negedge clk);
      // Reset state
      check("R11 reset fsr", 32'(fsr_q), 0);
      check("R11 reset far", far_q, 0);
      check("R11 reset grants", {grant_r, grant_w, grant_x, trap_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Full sweep: index x field x modified, traps on, no-fault off (R1 R2 R3 R4 R5 R10)
      for (int idx = 0; idx < 8; idx++) begin
         for (int fld = 0; fld < 8; fld++) begin
            for (int m = 0; m < 2; m++) begin
               clear_fsr();
               check("R7 cleared", 32'(fsr_q), 0);
               va = 32'h4000_0000 | (idx << 16) | (fld << 12) | (m << 8) | 32'h5;
               drive_req(idx, fld, m[0], va);
               #1;
               code = exp_code(idx, fld);
               rt   = exp_rights(~idx[0], fld);
               if (code == 0) begin
                  check("R3 R4 grants", {grant_r, grant_w, grant_x, trap_req},
                        {rt[2], rt[1] & m[0], rt[0], 1'b0});
               end else begin
                  check("R10 trap", {grant_r, grant_w, grant_x, trap_req, trap_inst},
                        {4'b0001, idx[1]});
               end
               @(negedge clk);
               idle();
               if (code == 0) begin
                  check("R1 no log", 32'(fsr_q), 0);
               end else begin
                  check("R1 R2 R5 fsr", 32'(fsr_q), (idx << 5) | code | 2);
                  check("R5 far", far_q, va);
               end
            end
         end
      end

      // Overflow chain (R6)
      clear_fsr();
      drive_req(0, 4, 1'b0, 32'h0000_1000);
      @(negedge clk);
      check("R5 first fault", 32'(fsr_q), 32'h00A);
      drive_req(4, 0, 1'b0, 32'h0000_2000);
      @(negedge clk);
      check("R6 overflow", 32'(fsr_q), 32'h08B);
      check("R6 far", far_q, 32'h0000_2000);
      drive_req(6, 6, 1'b1, 32'h0000_3000);
      @(negedge clk);
      check("R6 overflow again", 32'(fsr_q), 32'h0CF);

      // Read coinciding with a fault (R7)
      drive_req(3, 0, 1'b0, 32'h0000_4000);
      sts_rd = 1'b1;
      @(negedge clk);
      idle();
      check("R7 read plus fault", 32'(fsr_q), 32'h06A);

      // Walker code overrides an allowed check (R8)
      clear_fsr();
      drive_req(1, 3, 1'b1, 32'h0000_5000);
      walk_code = 12'h104;
      #1;
      check("R8 walk trap", {grant_r, grant_w, grant_x, trap_req, trap_inst}, 5'b00010);
      @(negedge clk);
      check("R8 walk fsr", 32'(fsr_q), 32'h126);
      drive_req(2, 2, 1'b0, 32'h0000_6000);
      walk_code = 12'h310;
      #1;
      check("R8 R10 walk fetch trap", {trap_req, trap_inst}, 2'b11);
      @(negedge clk);
      check("R8 R6 walk fsr", 32'(fsr_q), 32'h353);

      // No-fault and trap-disable overrides (R9)
      clear_fsr();
      nf_mode = 1'b1;
      drive_req(4, 6, 1'b0, 32'h0000_7000);
      #1;
      check("R9 nf full rights", {grant_r, grant_w, grant_x, trap_req}, 4'b1110);
      @(negedge clk);
      check("R9 nf logged", 32'(fsr_q), 32'h08E);
      drive_req(1, 1, 1'b0, 32'h0000_8000);
      #1;
      check("R9 R4 nf allowed keeps dirty rule", {grant_r, grant_w, grant_x, trap_req}, 4'b1000);
      @(negedge clk);
      check("R9 allowed not logged", 32'(fsr_q), 32'h08E);
      nf_mode = 1'b0;
      trap_en = 1'b0;
      drive_req(3, 0, 1'b0, 32'h0000_9000);
      #1;
      check("R9 traps off full rights", {grant_r, grant_w, grant_x, trap_req}, 4'b1110);
      @(negedge clk);
      check("R9 traps off logged", 32'(fsr_q), 32'h06B);
      trap_en = 1'b1;

      // Idle with faulting inputs (R11)
      drive_req(6, 7, 1'b0, 32'h0000_A000);
      req_valid = 1'b0;
      walk_code = 12'h104;
      #1;
      check("R11 idle outputs", {grant_r, grant_w, grant_x, trap_req}, 0);
      @(negedge clk);
      check("R11 idle fsr", 32'(fsr_q), 32'h06B);
      check("R11 idle far", far_q, 32'h0000_9000);
      idle();
      clear_fsr();
      check("R7 final clear", 32'(fsr_q), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule